// File: doc/BRIEF.md
# DMA Channel Transfer-Termination Controller

This block is the stop-and-status logic of a single DMA channel. After software starts a transfer, the block sequences each transfer unit. In dual-address operation a unit is a read phase followed by a write phase. In single-address operation it is one write phase. The block also counts units into blocks when block operation is selected. It decides the moment the channel stops and records why.

Four sources can stop a transfer. The first is the transfer counter stepping from 1 to 0. The second is a repeat-area overflow pulse from the source or destination address logic, when that side's enable is set. The third is a software stop request, and the fourth is a non-maskable abort. They differ in how long they let work continue. An abort cuts a block short and marks it as broken. A counter end, an overflow or a software stop lets the unit or block in flight finish. A write phase that follows a read is always completed. Bus timing, address arithmetic and arbitration between channels stay outside the block. They arrive only as the handshake inputs `req_acc` and `cyc_done` and as the overflow pulses.

The channel-active output is the completion indication. It falls exactly when the transfer has ended for any reason. Two sticky flags remain afterwards for software, and both are cleared only by write-one-to-clear strobes. The first is an interrupt-request flag with a one-cycle end-interrupt pulse. The second is a broken-block flag.

Top module: `dma_term_ctrl`

State machine: IDLE (channel inactive), WAIT (active, waiting for an accepted request), READ (read phase of a dual-address unit) and WRITE (write phase, or the only phase in single-address mode). The transitions are:
- IDLE→WAIT on `start`.
- WAIT→READ on an accepted request in dual-address mode.
- WAIT→WRITE on an accepted request in single-address mode.
- WAIT→IDLE when a stop cause is allowed to act.
- READ→WRITE on `cyc_done`.
- WRITE→WAIT on `cyc_done` with no stop.
- WRITE→IDLE on `cyc_done` with a stop.

## Requirements
- R1: In IDLE, `start` loads `count_load` and `active` is 1 after the next clock edge. A `start` while `active` is 1 is ignored and does not reload the counter.
- R2: An accepted request (`req_acc`) in dual-address mode (`dual_mode`=1) gives `bus_rd`=1 until `cyc_done`, then `bus_wr`=1 until `cyc_done`. In single-address mode it gives `bus_wr`=1 directly.
- R3: Outside block mode, a completed unit (write phase plus `cyc_done`) with counter value 1 ends the transfer, and `active` falls at that edge. If `cnt_end_ie`=1, `irf` is set and `end_irq` pulses for one cycle.
- R4: In block mode (`blk_mode`=1), one block is `blk_len` units (`blk_len` ≥ 1). Only counter bits [15:0] are decremented, once per completed block. The transfer ends by count when those bits are 1 at block completion, and the bits above 15 are ignored.
- R5: A counter loaded with 0 wraps on the first decrement, so reaching 0 does not end the transfer.
- R6: A `src_ovf` pulse with `src_ovf_ie`=1, or a `dst_ovf` pulse with `dst_ovf_ie`=1, ends the transfer after the unit in flight. In block mode it ends at the next block boundary. It sets `irf` and pulses `end_irq` whatever the value of `cnt_end_ie`. An overflow pulse whose enable is 0 is ignored.
- R7: `sw_stop` ends the transfer after the unit in flight or already accepted. In block mode it ends after the current block. `active` stays 1 until then, and `irf` is not set.
- R8: `nmi` ends the transfer at the next unit completion even in the middle of a block. If it arrives while waiting for a request, it ends the transfer at the next edge. If the block is left incomplete, `bef` is set. An abort never sets `irf`.
- R9: A stop or abort raised during a read phase still lets the following write phase run to its `cyc_done`.
- R10: In external-request mode (`ext_mode`=1), a request accepted in the same cycle as `nmi` is still served. With `ext_mode`=0 that request is dropped.
- R11: `irf` and `bef` stay set until `irf_clr` or `bef_clr` is pulsed. Starting a new transfer does not clear them.
- R12: Stop causes that act in the same cycle are resolved in the order abort, count end, overflow, software stop. Only the winner decides the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (ignored while active) |
| count_load | input | CNT_W | Initial transfer counter value |
| dual_mode | input | 1 | 1: read then write per unit; 0: one write per unit |
| blk_mode | input | 1 | Block operation select |
| blk_len | input | BLK_W | Units per block in block mode |
| ext_mode | input | 1 | External-request mode select |
| cnt_end_ie | input | 1 | Counter-end interrupt enable |
| src_ovf_ie | input | 1 | Source repeat-overflow stop enable |
| dst_ovf_ie | input | 1 | Destination repeat-overflow stop enable |
| req_acc | input | 1 | Transfer request accepted |
| cyc_done | input | 1 | Current bus phase finished |
| src_ovf | input | 1 | Source repeat-area overflow pulse |
| dst_ovf | input | 1 | Destination repeat-area overflow pulse |
| sw_stop | input | 1 | Software stop request |
| nmi | input | 1 | Non-maskable abort |
| irf_clr | input | 1 | Write-one-to-clear for `irf` |
| bef_clr | input | 1 | Write-one-to-clear for `bef` |
| active | output | 1 | Channel active |
| bus_rd | output | 1 | Read phase in progress |
| bus_wr | output | 1 | Write phase in progress |
| irf | output | 1 | Sticky interrupt-request flag |
| bef | output | 1 | Sticky broken-block flag |
| end_irq | output | 1 | One-cycle end-interrupt pulse |

## Verification
A stale latched stop cause shows up at the port as `active` falling one unit or one block early. A wrong unit count within a block shows up as the stop landing off the block boundary, together with a wrong `bef`. A mis-sequenced phase shows up on the first accepted request as `bus_rd` and `bus_wr` in the wrong order, or as a missing write phase. The counter-end comparison is exposed only on the final unit, so the test counts are chosen to make that unit land a few units after start, with upper counter bits set, and with a counter loaded at zero.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } chan_state_t;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_ABORT = 3'd1,
        CAUSE_COUNT = 3'd2,
        CAUSE_OVF   = 3'd3,
        CAUSE_SW    = 3'd4
    } stop_cause_t;
endpackage

// File: rtl/dma_term_counter.sv
module dma_term_counter #(
    parameter int CNT_W = 24,
    parameter int LOW_W = 16,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             blk_mode,
    input  logic [BLK_W-1:0] blk_len,
    input  logic             unit_done,
    output logic             count_end,
    output logic             blk_last,
    output logic             mid_block
);
    logic [CNT_W-1:0] cnt_q;
    logic [BLK_W-1:0] unit_q;
    logic             low_one;
    logic             full_one;

    assign low_one   = (cnt_q[LOW_W-1:0] == LOW_W'(1));
    assign full_one  = (cnt_q == CNT_W'(1));
    assign blk_last  = blk_mode ? (unit_q == blk_len - 1'b1) : 1'b1;
    assign mid_block = blk_mode && (unit_q != '0);
    assign count_end = unit_done && (blk_mode ? (blk_last && low_one) : full_one);

    generate
        if (CNT_W > LOW_W) begin : g_split
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    unit_q <= '0;
                end else if (load) begin
                    cnt_q  <= load_val;
                    unit_q <= '0;
                end else if (unit_done) begin
                    if (!blk_mode) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (blk_last) begin
                        unit_q <= '0;
                        cnt_q  <= {cnt_q[CNT_W-1:LOW_W], cnt_q[LOW_W-1:0] - 1'b1};
                    end else begin
                        unit_q <= unit_q + 1'b1;
                    end
                end
            end
        end else begin : g_flat
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    unit_q <= '0;
                end else if (load) begin
                    cnt_q  <= load_val;
                    unit_q <= '0;
                end else if (unit_done) begin
                    if (!blk_mode || blk_last) begin
                        cnt_q  <= cnt_q - 1'b1;
                        unit_q <= '0;
                    end else begin
                        unit_q <= unit_q + 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dma_term_cause.sv
module dma_term_cause (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic ovf_hit,
    input  logic sw_hit,
    input  logic abort_hit,
    output logic ovf_any,
    output logic sw_any,
    output logic abort_any
);
    logic ovf_q;
    logic sw_q;
    logic abort_q;

    assign ovf_any   = ovf_q   | (arm & ovf_hit);
    assign sw_any    = sw_q    | (arm & sw_hit);
    assign abort_any = abort_q | (arm & abort_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q   <= 1'b0;
            sw_q    <= 1'b0;
            abort_q <= 1'b0;
        end else if (clr) begin
            ovf_q   <= 1'b0;
            sw_q    <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            ovf_q   <= ovf_any;
            sw_q    <= sw_any;
            abort_q <= abort_any;
        end
    end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
    import dma_term_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int LOW_W = 16,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count_load,
    input  logic             dual_mode,
    input  logic             blk_mode,
    input  logic [BLK_W-1:0] blk_len,
    input  logic             ext_mode,
    input  logic             cnt_end_ie,
    input  logic             src_ovf_ie,
    input  logic             dst_ovf_ie,
    input  logic             req_acc,
    input  logic             cyc_done,
    input  logic             src_ovf,
    input  logic             dst_ovf,
    input  logic             sw_stop,
    input  logic             nmi,
    input  logic             irf_clr,
    input  logic             bef_clr,
    output logic             active,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             irf,
    output logic             bef,
    output logic             end_irq
);
    chan_state_t state_q, state_d;
    stop_cause_t cause;
    logic        incomplete;
    logic        unit_done;
    logic        load;
    logic        ovf_hit;
    logic        serve;
    logic        irq_set;
    logic        count_end, blk_last, mid_block;
    logic        ovf_any, sw_any, abort_any;

    assign unit_done = (state_q == S_WRITE) && cyc_done;
    assign load      = (state_q == S_IDLE) && start;
    assign ovf_hit   = (src_ovf && src_ovf_ie) || (dst_ovf && dst_ovf_ie);
    assign serve     = req_acc && (!abort_any || ext_mode);

    dma_term_counter #(
        .CNT_W(CNT_W),
        .LOW_W(LOW_W),
        .BLK_W(BLK_W)
    ) counter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (count_load),
        .blk_mode  (blk_mode),
        .blk_len   (blk_len),
        .unit_done (unit_done),
        .count_end (count_end),
        .blk_last  (blk_last),
        .mid_block (mid_block)
    );

    dma_term_cause cause_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (load || (cause != CAUSE_NONE)),
        .arm       (state_q != S_IDLE),
        .ovf_hit   (ovf_hit),
        .sw_hit    (sw_stop),
        .abort_hit (nmi),
        .ovf_any   (ovf_any),
        .sw_any    (sw_any),
        .abort_any (abort_any)
    );

    // next state and stop cause
    always_comb begin
        state_d    = state_q;
        cause      = CAUSE_NONE;
        incomplete = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (serve) begin
                    state_d = dual_mode ? S_READ : S_WRITE;
                end else if (abort_any) begin
                    cause      = CAUSE_ABORT;
                    incomplete = mid_block;
                end else if ((ovf_any || sw_any) && !mid_block) begin
                    cause = ovf_any ? CAUSE_OVF : CAUSE_SW;
                end
            end
            S_READ: begin
                if (cyc_done) state_d = S_WRITE;
            end
            S_WRITE: begin
                if (cyc_done) begin
                    state_d = S_WAIT;
                    if (abort_any) begin
                        cause      = CAUSE_ABORT;
                        incomplete = !blk_last;
                    end else if (count_end) begin
                        cause = CAUSE_COUNT;
                    end else if (ovf_any && blk_last) begin
                        cause = CAUSE_OVF;
                    end else if (sw_any && blk_last) begin
                        cause = CAUSE_SW;
                    end
                end
            end
        endcase
        if (cause != CAUSE_NONE) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign irq_set = ((cause == CAUSE_COUNT) && cnt_end_ie) || (cause == CAUSE_OVF);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irf     <= 1'b0;
            bef     <= 1'b0;
            end_irq <= 1'b0;
        end else begin
            irf     <= irq_set || (irf && !irf_clr);
            bef     <= ((cause == CAUSE_ABORT) && incomplete) || (bef && !bef_clr);
            end_irq <= irq_set;
        end
    end

    assign active = (state_q != S_IDLE);
    assign bus_rd = (state_q == S_READ);
    assign bus_wr = (state_q == S_WRITE);
endmodule

// File: rtl/dma_term_ctrl_chk.sv
module dma_term_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cyc_done,
    input logic nmi,
    input logic irf_clr,
    input logic active,
    input logic bus_rd,
    input logic bus_wr,
    input logic irf,
    input logic bef,
    input logic end_irq
);
    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start) |=> active);

    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && cyc_done) |=> bus_wr);

    assert_irq_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> $fell(active));

    assert_write_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cyc_done) |=> active);

    assert_bef_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bef) |-> $fell(active));

    assert_abort_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && nmi) |=> (bus_rd || bus_wr));

    assert_irq_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> irf);

    assert_irf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irf && !irf_clr) |=> irf);
endmodule

bind dma_term_ctrl dma_term_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cyc_done (cyc_done),
    .nmi      (nmi),
    .irf_clr  (irf_clr),
    .active   (active),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .irf      (irf),
    .bef      (bef),
    .end_irq  (end_irq)
);

// File: tb/dma_term_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_term_ctrl_tb_top;
    localparam int CNT_W = 24;
    localparam int BLK_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 0, dual_mode = 0, blk_mode = 0, ext_mode = 0;
    logic [CNT_W-1:0] count_load = '0;
    logic [BLK_W-1:0] blk_len = 8'd1;
    logic             cnt_end_ie = 0, src_ovf_ie = 0, dst_ovf_ie = 0;
    logic             req_acc = 0, cyc_done = 0, src_ovf = 0, dst_ovf = 0;
    logic             sw_stop = 0, nmi = 0, irf_clr = 0, bef_clr = 0;
    logic             active, bus_rd, bus_wr, irf, bef, end_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_term_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .count_load(count_load),
        .dual_mode(dual_mode), .blk_mode(blk_mode), .blk_len(blk_len),
        .ext_mode(ext_mode), .cnt_end_ie(cnt_end_ie), .src_ovf_ie(src_ovf_ie),
        .dst_ovf_ie(dst_ovf_ie), .req_acc(req_acc), .cyc_done(cyc_done),
        .src_ovf(src_ovf), .dst_ovf(dst_ovf), .sw_stop(sw_stop), .nmi(nmi),
        .irf_clr(irf_clr), .bef_clr(bef_clr), .active(active), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .irf(irf), .bef(bef), .end_irq(end_irq)
    );

    task automatic check(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic begin_xfer(input logic [CNT_W-1:0] val, input logic dual,
                              input logic blk, input logic [BLK_W-1:0] len);
        dual_mode  = dual;
        blk_mode   = blk;
        blk_len    = len;
        count_load = val;
        start      = 1;
        step();
        start      = 0;
    endtask

    task automatic one_unit();
        req_acc = 1;
        step();
        req_acc = 0;
        cyc_done = 1;
        if (dual_mode) step();
        step();
        cyc_done = 0;
    endtask

    task automatic clear_flags();
        irf_clr = 1;
        bef_clr = 1;
        step();
        irf_clr = 0;
        bef_clr = 0;
    endtask

    task automatic test_reset();
        check("reset active", active, 0);
        check("reset bus_rd", bus_rd, 0);
        check("reset bus_wr", bus_wr, 0);
        check("reset irf", irf, 0);
        check("reset bef", bef, 0);
        check("reset end_irq", end_irq, 0);
    endtask

    task automatic test_count_dual();
        cnt_end_ie = 1;
        begin_xfer(24'd3, 1, 0, 8'd1);
        check("R1 active after start", active, 1);
        req_acc = 1; step(); req_acc = 0;
        check("R2 read phase", bus_rd, 1);
        cyc_done = 1; step();
        check("R2 write phase", bus_wr, 1);
        check("R2 read over", bus_rd, 0);
        step(); cyc_done = 0;
        check("R3 still active count 2", active, 1);
        one_unit();
        check("R3 still active count 1", active, 1);
        one_unit();
        check("R3 end by count", active, 0);
        check("R3 irf set", irf, 1);
        check("R3 end_irq pulse", end_irq, 1);
        step();
        check("R3 end_irq one cycle", end_irq, 0);
        clear_flags();
        check("R11 irf cleared", irf, 0);
        cnt_end_ie = 0;
    endtask

    task automatic test_single();
        begin_xfer(24'd2, 0, 0, 8'd1);
        req_acc = 1; step(); req_acc = 0;
        check("R2 single goes to write", bus_wr, 1);
        check("R2 single no read", bus_rd, 0);
        cyc_done = 1; step(); cyc_done = 0;
        check("R3 single active", active, 1);
        one_unit();
        check("R3 single end", active, 0);
        check("R3 no irf without enable", irf, 0);
    endtask

    task automatic test_start_ignored();
        begin_xfer(24'd2, 0, 0, 8'd1);
        count_load = 24'd1; start = 1; step(); start = 0;
        one_unit();
        check("R1 restart ignored", active, 1);
        one_unit();
        check("R1 original count ends", active, 0);
    endtask

    task automatic test_zero_start();
        begin_xfer(24'd0, 1, 0, 8'd1);
        for (int i = 0; i < 3; i++) one_unit();
        check("R5 zero start no end", active, 1);
        sw_stop = 1; step(); sw_stop = 0;
        check("R7 stop while waiting", active, 0);
        check("R7 stop no irf", irf, 0);
    endtask

    task automatic test_sw_mid_cycle();
        begin_xfer(24'd10, 1, 0, 8'd1);
        req_acc = 1; step(); req_acc = 0;
        sw_stop = 1; step(); sw_stop = 0;
        check("R7 active during read", active, 1);
        check("R7 read continues", bus_rd, 1);
        cyc_done = 1; step();
        check("R9 write after stop", bus_wr, 1);
        check("R7 active during write", active, 1);
        step(); cyc_done = 0;
        check("R7 ends after unit", active, 0);
    endtask

    task automatic test_sw_block();
        begin_xfer(24'd50, 0, 1, 8'd3);
        one_unit();
        sw_stop = 1; step(); sw_stop = 0;
        check("R7 block not cut", active, 1);
        one_unit();
        check("R7 block unit 2", active, 1);
        one_unit();
        check("R7 end at boundary", active, 0);
        check("R7 block no bef", bef, 0);
    endtask

    task automatic test_block_count();
        cnt_end_ie = 1;
        begin_xfer(24'h100002, 0, 1, 8'd2);
        for (int i = 0; i < 3; i++) one_unit();
        check("R4 active before last block end", active, 1);
        one_unit();
        check("R4 end on low bits", active, 0);
        check("R4 irf", irf, 1);
        clear_flags();
        cnt_end_ie = 0;
    endtask

    task automatic test_ovf_block();
        src_ovf_ie = 1;
        begin_xfer(24'd100, 0, 1, 8'd3);
        one_unit();
        src_ovf = 1; step(); src_ovf = 0;
        check("R6 overflow waits for block", active, 1);
        one_unit();
        check("R6 block unit 2", active, 1);
        one_unit();
        check("R6 end at boundary", active, 0);
        check("R6 irf set", irf, 1);
        check("R6 end_irq", end_irq, 1);
        src_ovf_ie = 0;
    endtask

    task automatic test_ovf_single();
        begin_xfer(24'd100, 0, 0, 8'd1);
        check("R11 start keeps irf", irf, 1);
        clear_flags();
        dst_ovf = 1; step(); dst_ovf = 0;
        one_unit();
        check("R6 disabled overflow ignored", active, 1);
        dst_ovf_ie = 1;
        dst_ovf = 1; step(); dst_ovf = 0;
        check("R6 enabled overflow ends", active, 0);
        check("R6 irf from dst", irf, 1);
        clear_flags();
        dst_ovf_ie = 0;
    endtask

    task automatic test_nmi_block();
        begin_xfer(24'd5, 1, 1, 8'd4);
        one_unit();
        req_acc = 1; step(); req_acc = 0;
        nmi = 1; step(); nmi = 0;
        check("R9 read continues after abort", bus_rd, 1);
        cyc_done = 1; step();
        check("R9 write after abort", bus_wr, 1);
        step(); cyc_done = 0;
        check("R8 abort mid block", active, 0);
        check("R8 bef set", bef, 1);
        check("R8 no irf", irf, 0);
        clear_flags();
        check("R11 bef cleared", bef, 0);
    endtask

    task automatic test_nmi_boundary();
        begin_xfer(24'd5, 0, 1, 8'd2);
        one_unit();
        one_unit();
        nmi = 1; step(); nmi = 0;
        check("R8 abort while waiting", active, 0);
        check("R8 no bef at boundary", bef, 0);
    endtask

    task automatic test_ext();
        ext_mode = 1;
        begin_xfer(24'd10, 1, 0, 8'd1);
        nmi = 1; req_acc = 1; step(); nmi = 0; req_acc = 0;
        check("R10 acknowledged request served", bus_rd, 1);
        cyc_done = 1; step(); step(); cyc_done = 0;
        check("R10 ends after served unit", active, 0);
        ext_mode = 0;
        begin_xfer(24'd10, 1, 0, 8'd1);
        nmi = 1; req_acc = 1; step(); nmi = 0; req_acc = 0;
        check("R10 non-ext request dropped", bus_rd, 0);
        check("R10 non-ext ends", active, 0);
    endtask

    task automatic test_priority();
        src_ovf_ie = 1;
        begin_xfer(24'd1, 0, 0, 8'd1);
        req_acc = 1; step(); req_acc = 0;
        src_ovf = 1; cyc_done = 1; step(); src_ovf = 0; cyc_done = 0;
        check("R12 count beats overflow end", active, 0);
        check("R12 count beats overflow irf", irf, 0);
        src_ovf_ie = 0;
        cnt_end_ie = 1;
        begin_xfer(24'd1, 0, 0, 8'd1);
        req_acc = 1; step(); req_acc = 0;
        nmi = 1; cyc_done = 1; step(); nmi = 0; cyc_done = 0;
        check("R12 abort beats count end", active, 0);
        check("R12 abort beats count irf", irf, 0);
        check("R12 abort beats count pulse", end_irq, 0);
        cnt_end_ie = 0;
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12;
        test_reset();
        rst_n = 1;
        step();
        test_count_dual();
        test_single();
        test_start_ignored();
        test_zero_start();
        test_sw_mid_cycle();
        test_sw_block();
        test_block_count();
        test_ovf_block();
        test_ovf_single();
        test_nmi_block();
        test_nmi_boundary();
        test_ext();
        test_priority();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule